// File: doc/BRIEF.md
# SIMD float-to-fixed truncating converter

This block converts a 128-bit vector of IEEE binary floating-point lanes into signed fixed-point integers. Each result is as wide as its source lane. Lanes are either 16-bit half precision or 32-bit single precision. Before truncation, each lane can be scaled by a power of two given by a fractional-bit count. Any remaining fraction is dropped by rounding toward zero. Values that fall outside the signed range of the lane clamp to the nearest end of that range. Two status bits report invalid and inexact conversions. Both bits are sticky and are cleared only by reset.

A width select limits the active lanes to the low 64 bits or extends them to all 128 bits. A scalar control converts only lane 0. In scalar mode, a merge control decides what the bits above that lane hold: either the previous destination value or zero. A conversion is requested by pulsing `in_valid` for one cycle. One cycle later the result is registered, and `out_valid` is high in that cycle.

A two-state output controller tracks whether a fresh result is present. Its states are `ST_EMPTY` and `ST_FULL`, with these transitions:
- `ST_EMPTY` to `ST_FULL` when `in_valid` is high.
- `ST_FULL` to `ST_FULL` when `in_valid` is high again.
- `ST_FULL` to `ST_EMPTY` when `in_valid` is low.
- `ST_EMPTY` to `ST_EMPTY` otherwise.

Top module: `simd_ftofix_trunc`

## Requirements
- R1: The lane size is selected by `elem_half`: 1 gives eight 16-bit half lanes (5 exponent bits, 10 fraction bits), 0 gives four 32-bit single lanes (8 exponent bits, 23 fraction bits). Lane i occupies bits [i*W +: W] of both `src` and `result`, and each lane converts independently.
- R2: The fractional part left after scaling is discarded toward zero for both signs. For example, 1.5 gives 1, -1.5 gives -1, -0.75 gives 0 and 2.5 gives 2.
- R3: Each value is multiplied by 2^`fbits` before truncation. `fbits` = 0 gives a plain integer conversion. Counts larger than the lane width act as the lane width.
- R4: A result above 2^(W-1)-1 becomes 2^(W-1)-1, and a result below -2^(W-1) becomes -2^(W-1). Infinities clamp the same way according to their sign. Every clamp sets the invalid status. -2^(W-1) itself converts exactly and does not clamp.
- R5: A NaN lane (all-ones exponent, nonzero fraction) yields 0 and sets the invalid status.
- R6: With `wide` = 0 and `scalar` = 0, only the lanes in bits [63:0] are active, and `result[127:64]` is zero.
- R7: With `scalar` = 1, only lane 0 is converted. The bits above lane 0 come from `old_dst` when `merge` = 1 and are zero when `merge` = 0. `merge` has no effect when `scalar` = 0.
- R8: The inexact status is set when nonzero fraction bits are discarded from a lane that did not clamp. Zeros of either sign convert exactly to 0. A subnormal with `fbits` = 0 gives 0 and sets inexact.
- R9: `flag_invalid` and `flag_inexact` accumulate the status of the active lanes of every conversion since reset. Inactive lanes never set them.
- R10: One cycle after `in_valid` is high, `out_valid` is 1 and `result` holds the converted vector. In a cycle after `in_valid` was low, `out_valid` is 0 and `result` is unchanged.
- R11: During reset, `out_valid`, `result`, `flag_invalid` and `flag_inexact` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Start a conversion of the present inputs |
| elem_half | input | 1 | 1: 16-bit half lanes, 0: 32-bit single lanes |
| wide | input | 1 | 1: all 128 bits active, 0: low 64 bits only |
| scalar | input | 1 | Convert lane 0 only |
| merge | input | 1 | In scalar mode, keep `old_dst` above lane 0 |
| fbits | input | 6 | Fractional-bit count (power-of-two scale) |
| src | input | 128 | Source floating-point vector |
| old_dst | input | 128 | Previous destination value for merging |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 128 | Converted fixed-point vector |
| flag_invalid | output | 1 | Sticky invalid status |
| flag_inexact | output | 1 | Sticky inexact status |

## Verification
The only state held in the block is the output controller state, the result register and the two sticky status bits. A wrong controller state shows at `out_valid` in the cycle after a request, or in the cycle after an idle cycle. A status bit that is lost or wrongly set stays wrong at the port until reset, because it is sticky. The bench therefore tracks its own accumulated status and compares it after every conversion. A fault in the lane datapath, such as a bad exponent offset, shift or clamp limit, shows at `result` in the very next cycle. The bench targets these faults with directed values at the exact clamp boundaries, at halves of a unit and at subnormals, then adds seeded random lanes with exponents near the integer range.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int VEC_W    = 128;
    localparam int HALF_W   = 16;
    localparam int HALF_E   = 5;
    localparam int HALF_M   = 10;
    localparam int SINGLE_W = 32;
    localparam int SINGLE_E = 8;
    localparam int SINGLE_M = 23;
    localparam int FBITS_W  = 6;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_t;

    typedef struct packed {
        logic invalid;
        logic inexact;
    } lane_flags_t;
endpackage

// File: rtl/fx_lane_cvt.sv
module fx_lane_cvt
    import fcvt_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int EXP_W  = 8,
    parameter int MAN_W  = 23
) (
    input  logic [LANE_W-1:0]  val_i,
    input  logic [FBITS_W-1:0] fbits_i,
    output logic [LANE_W-1:0]  res_o,
    output lane_flags_t        flags_o
);
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int SIG_W = MAN_W + 1;
    localparam int SE_W  = EXP_W + 3;
    localparam int MAG_W = SIG_W + LANE_W;
    localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] NEG_MIN = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [MAG_W-1:0]  MAG_NEG_LIM = MAG_W'(1) << (LANE_W - 1);
    localparam logic [MAG_W-1:0]  MAG_POS_LIM = MAG_NEG_LIM - MAG_W'(1);

    logic               sign;
    logic [EXP_W-1:0]   ex;
    logic [MAN_W-1:0]   mn;
    assign {sign, ex, mn} = val_i;

    logic ex_all1, ex_zero, is_nan, is_inf, is_zero;
    assign ex_all1 = &ex;
    assign ex_zero = ~|ex;
    assign is_nan  = ex_all1 & (|mn);
    assign is_inf  = ex_all1 & ~(|mn);
    assign is_zero = ex_zero & ~(|mn);

    logic [SIG_W-1:0] sig;
    assign sig = {~ex_zero, mn};

    // scale by 2^fbits: add the clamped count to the exponent
    logic [FBITS_W-1:0] fb_eff;
    assign fb_eff = (fbits_i > FBITS_W'(LANE_W)) ? FBITS_W'(LANE_W) : fbits_i;

    logic [SE_W-1:0] ex_eff, se, rs;
    logic            se_neg;
    assign ex_eff = ex_zero ? SE_W'(1) : SE_W'(ex);
    assign se     = ex_eff + SE_W'(fb_eff) - SE_W'(BIAS + MAN_W);
    assign se_neg = se[SE_W-1];
    assign rs     = SE_W'(0) - se;

    logic [MAG_W-1:0] mag;
    logic             lost;
    logic             big;

    always_comb begin
        mag  = '0;
        lost = 1'b0;
        big  = 1'b0;
        if (!se_neg) begin
            if (se >= SE_W'(LANE_W)) begin
                big = 1'b1;
            end else begin
                mag = MAG_W'(sig) << se;
            end
        end else if (rs >= SE_W'(SIG_W)) begin
            lost = |sig;
        end else begin
            mag  = MAG_W'(sig >> rs);
            lost = |(sig & ~({SIG_W{1'b1}} << rs));
        end
    end

    logic over, sat;
    assign over = big | (sign ? (mag > MAG_NEG_LIM) : (mag > MAG_POS_LIM));
    assign sat  = is_inf | (~ex_all1 & ~is_zero & over);

    logic [LANE_W-1:0] mag_w;
    assign mag_w = mag[LANE_W-1:0];

    always_comb begin
        if (is_nan) begin
            res_o = '0;
        end else if (sat) begin
            res_o = sign ? NEG_MIN : POS_MAX;
        end else begin
            res_o = sign ? (LANE_W'(0) - mag_w) : mag_w;
        end
        flags_o.invalid = is_nan | sat;
        flags_o.inexact = ~ex_all1 & ~sat & lost;
    end

    always_comb begin
        AST_SIGN_KEPT: assert (is_nan || sat || res_o == '0 || res_o[LANE_W-1] == sign); // R2
        AST_FLAG_EXCL: assert (!(flags_o.invalid && flags_o.inexact)); // R8
    end
endmodule

// File: rtl/fx_vec_pack.sv
module fx_vec_pack
    import fcvt_pkg::*;
#(
    parameter int P_VEC_W    = 128,
    parameter int P_HALF_W   = 16,
    parameter int P_SINGLE_W = 32
) (
    input  logic                               elem_half,
    input  logic                               wide,
    input  logic                               scalar,
    input  logic                               merge,
    input  logic [P_VEC_W-1:0]                 old_dst,
    input  logic [P_VEC_W-1:0]                 half_vec,
    input  logic [P_VEC_W-1:0]                 single_vec,
    input  logic [P_VEC_W/P_HALF_W-1:0]        half_inv,
    input  logic [P_VEC_W/P_HALF_W-1:0]        half_inx,
    input  logic [P_VEC_W/P_SINGLE_W-1:0]      single_inv,
    input  logic [P_VEC_W/P_SINGLE_W-1:0]      single_inx,
    output logic [P_VEC_W-1:0]                 vec_o,
    output logic                               inv_o,
    output logic                               inx_o
);
    localparam int NH = P_VEC_W / P_HALF_W;
    localparam int NS = P_VEC_W / P_SINGLE_W;

    logic              keep_old;
    logic [NH-1:0]     h_act;
    logic [NS-1:0]     s_act;
    logic [P_VEC_W-1:0] h_out, s_out;

    assign keep_old = scalar & merge;

    for (genvar i = 0; i < NH; i++) begin : g_half
        assign h_act[i] = scalar ? (i == 0) : (wide | (i < NH / 2));
        assign h_out[i*P_HALF_W +: P_HALF_W] =
            h_act[i] ? half_vec[i*P_HALF_W +: P_HALF_W] :
            (keep_old ? old_dst[i*P_HALF_W +: P_HALF_W] : '0);
    end

    for (genvar j = 0; j < NS; j++) begin : g_single
        assign s_act[j] = scalar ? (j == 0) : (wide | (j < NS / 2));
        assign s_out[j*P_SINGLE_W +: P_SINGLE_W] =
            s_act[j] ? single_vec[j*P_SINGLE_W +: P_SINGLE_W] :
            (keep_old ? old_dst[j*P_SINGLE_W +: P_SINGLE_W] : '0);
    end

    always_comb begin
        if (elem_half) begin
            vec_o = h_out;
            inv_o = |(half_inv & h_act);
            inx_o = |(half_inx & h_act);
        end else begin
            vec_o = s_out;
            inv_o = |(single_inv & s_act);
            inx_o = |(single_inx & s_act);
        end
    end
endmodule

// File: rtl/fx_out_fsm.sv
module fx_out_fsm
    import fcvt_pkg::*;
#(
    parameter int P_VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [P_VEC_W-1:0] vec_i,
    input  logic               inv_i,
    input  logic               inx_i,
    output logic               out_valid,
    output logic [P_VEC_W-1:0] result,
    output logic               flag_invalid,
    output logic               flag_inexact
);
    out_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_FULL;
            ST_FULL:  if (!in_valid) state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else if (in_valid) begin
            result       <= vec_i;
            flag_invalid <= flag_invalid | inv_i;
            flag_inexact <= flag_inexact | inx_i;
        end
    end

    assign out_valid = (state_q == ST_FULL);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R10
    AST_STICKY_INV: assert property (@(posedge clk) disable iff (!rst_n) flag_invalid |=> flag_invalid); // R9
    AST_STICKY_INX: assert property (@(posedge clk) disable iff (!rst_n) flag_inexact |=> flag_inexact); // R9
endmodule

// File: rtl/simd_ftofix_trunc.sv
module simd_ftofix_trunc
    import fcvt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               elem_half,
    input  logic               wide,
    input  logic               scalar,
    input  logic               merge,
    input  logic [5:0]         fbits,
    input  logic [127:0]       src,
    input  logic [127:0]       old_dst,
    output logic               out_valid,
    output logic [127:0]       result,
    output logic               flag_invalid,
    output logic               flag_inexact
);
    localparam int NH = VEC_W / HALF_W;
    localparam int NS = VEC_W / SINGLE_W;

    logic [VEC_W-1:0] half_vec, single_vec, packed_vec;
    logic [NH-1:0]    half_inv, half_inx;
    logic [NS-1:0]    single_inv, single_inx;
    logic             pk_inv, pk_inx;

    for (genvar i = 0; i < NH; i++) begin : g_hcvt
        lane_flags_t fl;
        fx_lane_cvt #(
            .LANE_W (HALF_W),
            .EXP_W  (HALF_E),
            .MAN_W  (HALF_M)
        ) u_lane (
            .val_i   (src[i*HALF_W +: HALF_W]),
            .fbits_i (fbits),
            .res_o   (half_vec[i*HALF_W +: HALF_W]),
            .flags_o (fl)
        );
        assign half_inv[i] = fl.invalid;
        assign half_inx[i] = fl.inexact;
    end

    for (genvar j = 0; j < NS; j++) begin : g_scvt
        lane_flags_t fl;
        fx_lane_cvt #(
            .LANE_W (SINGLE_W),
            .EXP_W  (SINGLE_E),
            .MAN_W  (SINGLE_M)
        ) u_lane (
            .val_i   (src[j*SINGLE_W +: SINGLE_W]),
            .fbits_i (fbits),
            .res_o   (single_vec[j*SINGLE_W +: SINGLE_W]),
            .flags_o (fl)
        );
        assign single_inv[j] = fl.invalid;
        assign single_inx[j] = fl.inexact;
    end

    fx_vec_pack #(
        .P_VEC_W    (VEC_W),
        .P_HALF_W   (HALF_W),
        .P_SINGLE_W (SINGLE_W)
    ) u_pack (
        .elem_half  (elem_half),
        .wide       (wide),
        .scalar     (scalar),
        .merge      (merge),
        .old_dst    (old_dst),
        .half_vec   (half_vec),
        .single_vec (single_vec),
        .half_inv   (half_inv),
        .half_inx   (half_inx),
        .single_inv (single_inv),
        .single_inx (single_inx),
        .vec_o      (packed_vec),
        .inv_o      (pk_inv),
        .inx_o      (pk_inx)
    );

    fx_out_fsm #(
        .P_VEC_W (VEC_W)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .vec_i        (packed_vec),
        .inv_i        (pk_inv),
        .inx_i        (pk_inx),
        .out_valid    (out_valid),
        .result       (result),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact)
    );

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide && !scalar) |=> (result[127:64] == '0)); // R6
    AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scalar && merge && !elem_half) |=> (result[127:32] == $past(old_dst[127:32]))); // R7
    AST_SCALAR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && scalar && !merge && elem_half) |=> (result[127:16] == '0)); // R7
endmodule

// File: tb/simd_ftofix_trunc_tb_top.sv
module simd_ftofix_trunc_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         elem_half = 1'b0;
    logic         wide = 1'b0;
    logic         scalar = 1'b0;
    logic         merge = 1'b0;
    logic [5:0]   fbits = '0;
    logic [127:0] src = '0;
    logic [127:0] old_dst = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         flag_invalid;
    logic         flag_inexact;

    int checks = 0;
    int errors = 0;
    logic st_inv = 1'b0;
    logic st_inx = 1'b0;

    always #10 clk = ~clk;

    simd_ftofix_trunc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_half(elem_half),
        .wide(wide), .scalar(scalar), .merge(merge), .fbits(fbits), .src(src),
        .old_dst(old_dst), .out_valid(out_valid), .result(result),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // returns {invalid, inexact, value[31:0]}
    function automatic logic [33:0] lane_ref(input logic [31:0] b, input bit h, input int fb);
        int W = h ? 16 : 32;
        int E = h ? 5 : 8;
        int M = h ? 10 : 23;
        int bias = (1 << (E - 1)) - 1;
        int sg = int'((b >> (W - 1)) & 32'd1);
        int ex = int'((b >> M) & ((32'd1 << E) - 1));
        int mn = int'(b & ((32'd1 << M) - 1));
        int fe = (fb > W) ? W : fb;
        logic [31:0] pmax = h ? 32'h7FFF : 32'h7FFFFFFF;
        logic [31:0] nmin = h ? 32'h8000 : 32'h80000000;
        real mag;
        real lim;
        longint iv;
        logic [63:0] iv_bits;
        lim = 2.0 ** real'(W - 1);
        if (ex == (1 << E) - 1) begin
            if (mn != 0) return {2'b10, 32'd0};
            return {2'b10, (sg != 0) ? nmin : pmax};
        end
        if (ex == 0) mag = real'(mn) * (2.0 ** real'(1 - bias - M + fe));
        else         mag = real'(mn + (1 << M)) * (2.0 ** real'(ex - bias - M + fe));
        if ((sg == 0 && mag >= lim) || (sg != 0 && mag > lim))
            return {2'b10, (sg != 0) ? nmin : pmax};
        iv = longint'($floor(mag));
        if (sg != 0) iv = -iv;
        iv_bits = iv;
        return {1'b0, ($floor(mag) != mag), iv_bits[31:0]};
    endfunction

    task automatic expect_vec(input logic [127:0] s, input bit h, input bit w, input bit sc,
                              input bit mg, input int fb, input logic [127:0] od,
                              output logic [127:0] ev, output logic ei, output logic ex);
        int lw = h ? 16 : 32;
        int n = 128 / lw;
        logic [127:0] m128 = h ? 128'hFFFF : 128'hFFFFFFFF;
        ev = '0; ei = 1'b0; ex = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit act = sc ? (i == 0) : (w || i < n / 2);
            logic [31:0] lb = 32'((s >> (i * lw)) & m128);
            if (act) begin
                logic [33:0] r = lane_ref(lb, h, fb);
                ev = ev | ((128'(r[31:0]) & m128) << (i * lw));
                ei = ei | r[33];
                ex = ex | r[32];
            end else if (sc && mg) begin
                ev = ev | (((od >> (i * lw)) & m128) << (i * lw));
            end
        end
    endtask

    task automatic run_op(input logic [127:0] s, input bit h, input bit w, input bit sc,
                          input bit mg, input logic [5:0] fb, input logic [127:0] od, input string req);
        logic [127:0] ev;
        logic ei, ex;
        @(negedge clk);
        src = s; elem_half = h; wide = w; scalar = sc; merge = mg; fbits = fb; old_dst = od;
        in_valid = 1'b1;
        expect_vec(s, h, w, sc, mg, int'(fb), od, ev, ei, ex);
        @(negedge clk);
        in_valid = 1'b0;
        st_inv = st_inv | ei;
        st_inx = st_inx | ex;
        chk(out_valid == 1'b1, "R10 out_valid after request", 128'(out_valid), 128'd1);
        chk(result == ev, {req, " result"}, result, ev);
        chk(flag_invalid == st_inv, "R9 sticky invalid", 128'(flag_invalid), 128'(st_inv));
        chk(flag_inexact == st_inx, "R9 sticky inexact", 128'(flag_inexact), 128'(st_inx));
    endtask

    function automatic logic [127:0] rnd_vec(input bit h);
        logic [127:0] v = '0;
        if (h) begin
            for (int i = 0; i < 8; i++) begin
                logic [15:0] x;
                logic [4:0] e;
                x = 16'($urandom);
                e = ($urandom % 4 == 0) ? 5'($urandom) : 5'(12 + $urandom % 20);
                x[14:10] = e;
                v[i*16 +: 16] = x;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                logic [31:0] x;
                logic [7:0] e;
                x = $urandom;
                e = ($urandom % 4 == 0) ? 8'($urandom) : 8'(124 + $urandom % 36);
                x[30:23] = e;
                v[i*32 +: 32] = x;
            end
        end
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11 reset out_valid", 128'(out_valid), 128'd0);
        chk(result == '0, "R11 reset result", result, 128'd0);
        chk(flag_invalid == 1'b0 && flag_inexact == 1'b0, "R11 reset flags",
            128'({flag_invalid, flag_inexact}), 128'd0);
        rst_n = 1'b1;

        run_op({4{32'h3F800000}}, 0, 1, 0, 0, 6'd0, '0, "R1 single ones");
        chk(result == {4{32'h00000001}}, "R1 literal ones", result, {4{32'h00000001}});
        run_op({32'h00000000, 32'h80000000, 32'h00000000, 32'h80000000}, 0, 1, 0, 0, 6'd0, '0, "R8 zeros exact");
        chk(flag_inexact == 1'b0, "R8 zeros no inexact", 128'(flag_inexact), 128'd0);
        run_op({112'd0, 16'h0001}, 1, 1, 0, 0, 6'd0, '0, "R8 half subnormal");
        chk(flag_inexact == 1'b1, "R8 subnormal inexact", 128'(flag_inexact), 128'd1);
        run_op({32'h7FC00000, 32'h7FC00000, 32'h3F800000, 32'h3F800000}, 0, 0, 0, 0, 6'd0, '0, "R9 inactive NaN");
        chk(flag_invalid == 1'b0, "R9 inactive lanes no invalid", 128'(flag_invalid), 128'd0);
        run_op({32'h40200000, 32'hBF400000, 32'hBFC00000, 32'h3FC00000}, 0, 1, 0, 0, 6'd0, '0, "R2 truncation");
        chk(result == {32'h2, 32'h0, 32'hFFFFFFFF, 32'h1}, "R2 literal truncation",
            result, {32'h2, 32'h0, 32'hFFFFFFFF, 32'h1});
        run_op({96'd0, 32'h3FC00000}, 0, 1, 0, 0, 6'd8, '0, "R3 scale by 8");
        chk(result[31:0] == 32'd384, "R3 literal 1.5*2^8", 128'(result[31:0]), 128'd384);
        run_op({96'd0, 32'h3FC00000}, 0, 1, 0, 0, 6'd40, '0, "R3 clamped count");
        chk(result[31:0] == 32'h7FFFFFFF, "R3 count over width", 128'(result[31:0]), 128'h7FFFFFFF);
        run_op({32'hFF800000, 32'h7F800000, 32'hCF000000, 32'h4F000000}, 0, 1, 0, 0, 6'd0, '0, "R4 clamp");
        chk(result == {32'h80000000, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF}, "R4 literal clamp",
            result, {32'h80000000, 32'h7FFFFFFF, 32'h80000000, 32'h7FFFFFFF});
        run_op({4{32'h7FC00000}}, 0, 1, 0, 0, 6'd0, '0, "R5 NaN");
        chk(result == '0, "R5 NaN gives zero", result, 128'd0);
        run_op({8{16'h3C00}}, 1, 0, 0, 1, 6'd0, {8{16'hA5A5}}, "R6 narrow half");
        chk(result[127:64] == '0, "R6 upper zero", 128'(result[127:64]), 128'd0);
        run_op({8{16'h4500}}, 1, 1, 1, 1, 6'd0, {8{16'hA5A5}}, "R7 scalar merge");
        chk(result == {{7{16'hA5A5}}, 16'd5}, "R7 literal merge", result, {{7{16'hA5A5}}, 16'd5});
        run_op({4{32'h40A00000}}, 0, 1, 1, 0, 6'd0, {4{32'h5A5A5A5A}}, "R7 scalar clear");
        chk(result == {96'd0, 32'd5}, "R7 literal clear", result, {96'd0, 32'd5});

        held = result;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 idle out_valid", 128'(out_valid), 128'd0);
        chk(result == held, "R10 result held", result, held);

        for (int k = 0; k < 300; k++) begin
            bit h = 1'($urandom);
            logic [5:0] fb = ($urandom % 2 == 0) ? 6'd0 : 6'($urandom % 41);
            run_op(rnd_vec(h), h, 1'($urandom), 1'($urandom % 4 == 0), 1'($urandom),
                   fb, {$urandom, $urandom, $urandom, $urandom}, "R1 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule